// File: doc/BRIEF.md
# Pin function mux register bank

This block holds the function select for every pin of one GPIO bank of up to 32 pins. The pins form four groups of eight. A parameter gives each group one of three layouts. A 2-bit group keeps one register with a two-bit field per pin. A 4-bit group spreads its eight four-bit fields over two consecutive registers. A GPIO-only group has no register, and its pins are fixed to function 0.

Software reaches the registers over a plain 32-bit bus, word-aligned and byte-addressed from the bank base. Each write carries its own per-bit enable in the upper halfword, so one field can change without a read-modify-write. Every pin gets a 4-bit function code on a flat output vector, which the pad logic uses to pick the function.

Top module: `pinmux_regbank`

## Requirements
- R1: After reset every function field is 0, so every pin outputs function 0 and every mapped register reads 0.
- R2: Register offsets are assigned to the groups in order from offset 0x00. A 2-bit group takes 4 bytes, a 4-bit group takes 8 bytes and a GPIO-only group takes none. With the default layout (group0 2-bit, group1 4-bit, group2 GPIO-only, group3 4-bit) the registers sit at 0x00, 0x04/0x08 and 0x0C/0x10.
- R3: In a 2-bit group, pin p of the group is held in register bits [2p+1:2p], and the register reads back as a 16-bit value.
- R4: In a 4-bit group, pins 0 to 3 of the group sit in the first register and pins 4 to 7 in the register at +4 bytes. Pin p uses bits [4(p mod 4)+3 : 4(p mod 4)].
- R5: On a write, data bit n (n < 16) is stored only when write bit n+16 is 1. Bits whose enable is 0 keep their value.
- R6: Bits [31:16] of any read are 0.
- R7: Pins of a GPIO-only group always output function 0.
- R8: A write to an offset that maps to no register changes nothing, and a read from such an offset returns 0. Misaligned offsets are unmapped.
- R9: Pin i drives func_o[4i+3:4i]. In a 2-bit group the upper two bits of that code are 0.
- R10: A write takes effect at the rising clock edge where wr_i is high. rdata_o follows addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte offset from the bank base |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Bits [31:16] are the write enables, bits [15:0] the data |
| rdata_o | output | 32 | Read data for addr_i |
| func_o | output | NUM_GROUPS*32 (128) | 4-bit function code per pin |

## Verification
The bench targets the 4-bit groups' second register, which catches a design that puts pins 4 to 7 in the wrong word or at bit offsets based on pin mod 8. It also places a 4-bit group after a GPIO-only group, so a design that reserves offset space for GPIO-only groups would move group 3 to the wrong address. Partial-mask writes show whether fields outside the mask are wrongly cleared. Writes to a hole offset and to a misaligned offset would expose a decoder that only partly compares the address. It also checks function values before and after the write edge, which shows up a write that takes effect one cycle early or one cycle late.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam logic [1:0] KIND_GPIO = 2'd0;
  localparam logic [1:0] KIND_W2   = 2'd1;
  localparam logic [1:0] KIND_W4   = 2'd2;

  localparam int PINS_PER_GROUP = 8;
  localparam int FUNC_W         = 4;

  function automatic logic [1:0] kind_of(input logic [7:0] kinds, input int g);
    return kinds[2*g +: 2];
  endfunction

  function automatic int span_of(input logic [1:0] kind);
    case (kind)
      KIND_W2: return 4;
      KIND_W4: return 8;
      default: return 0;
    endcase
  endfunction

  // byte offset of a group's first register
  function automatic int group_base(input logic [7:0] kinds, input int g);
    int acc;
    acc = 0;
    for (int h = 0; h < g; h++) acc += span_of(kind_of(kinds, h));
    return acc;
  endfunction

  function automatic logic addr_mapped(input logic [7:0] kinds, input int ngroups,
                                       input int addr);
    logic hit;
    hit = 1'b0;
    for (int g = 0; g < ngroups; g++) begin
      if (kind_of(kinds, g) != KIND_GPIO && addr == group_base(kinds, g)) hit = 1'b1;
      if (kind_of(kinds, g) == KIND_W4 && addr == group_base(kinds, g) + 4) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/pinmux_mreg.sv
module pinmux_mreg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [15:0] q_o
);
  logic [15:0] bit_en;
  assign bit_en = wdata_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (q_o & ~bit_en) | (wdata_i[15:0] & bit_en);
  end
endmodule

// File: rtl/pinmux_group.sv
module pinmux_group #(
  parameter logic [1:0] KIND   = pinmux_pkg::KIND_W2,
  parameter int         BASE   = 0,
  parameter int         ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [31:0]         wdata_i,
  output logic [15:0]         rdata_o,
  output logic [8*4-1:0]      func_o
);
  import pinmux_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(BASE + 4);

  logic        hit_lo;
  logic [15:0] q_lo;

  assign hit_lo = (addr_i == ADDR_LO);

  pinmux_mreg u_reg_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i && hit_lo),
    .wdata_i(wdata_i), .q_o(q_lo)
  );

  if (KIND == KIND_W4) begin : g_w4
    logic        hit_hi;
    logic [15:0] q_hi;
    assign hit_hi = (addr_i == ADDR_HI);

    pinmux_mreg u_reg_hi (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i && hit_hi),
      .wdata_i(wdata_i), .q_o(q_hi)
    );

    assign rdata_o = hit_lo ? q_lo : (hit_hi ? q_hi : 16'h0);
    for (genvar p = 0; p < 4; p++) begin : g_pin
      assign func_o[FUNC_W*p +: FUNC_W]     = q_lo[4*p +: 4];
      assign func_o[FUNC_W*(p+4) +: FUNC_W] = q_hi[4*p +: 4];
    end
  end else begin : g_w2
    assign rdata_o = hit_lo ? q_lo : 16'h0;
    for (genvar p = 0; p < PINS_PER_GROUP; p++) begin : g_pin
      assign func_o[FUNC_W*p +: FUNC_W] = {2'b00, q_lo[2*p +: 2]};
    end
  end
endmodule

// File: rtl/pinmux_regbank.sv
module pinmux_regbank #(
  parameter int         NUM_GROUPS  = 4,
  parameter logic [7:0] GROUP_KINDS = 8'b10_00_10_01,
  parameter int         ADDR_W      = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_GROUPS*32-1:0]  func_o
);
  import pinmux_pkg::*;

  localparam int GRP_FUNC_W = PINS_PER_GROUP * FUNC_W;

  logic [15:0] grp_rd [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [1:0] KIND = kind_of(GROUP_KINDS, g);
    if (KIND == KIND_GPIO) begin : g_gpio
      assign grp_rd[g]                       = '0;
      assign func_o[g*GRP_FUNC_W +: GRP_FUNC_W] = '0;
    end else begin : g_mux
      pinmux_group #(
        .KIND(KIND), .BASE(group_base(GROUP_KINDS, g)), .ADDR_W(ADDR_W)
      ) u_group (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(grp_rd[g]),
        .func_o(func_o[g*GRP_FUNC_W +: GRP_FUNC_W])
      );
    end
  end

  // offsets are disjoint, so an OR is the read mux
  logic [15:0] rd_or;
  always_comb begin
    rd_or = '0;
    for (int g = 0; g < NUM_GROUPS; g++) rd_or |= grp_rd[g];
  end
  assign rdata_o = {16'h0, rd_or};
endmodule

// File: rtl/pinmux_regbank_chk.sv
module pinmux_regbank_chk #(
  parameter int         NUM_GROUPS  = 4,
  parameter logic [7:0] GROUP_KINDS = 8'b10_00_10_01,
  parameter int         ADDR_W      = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      wr_i,
  input logic [31:0]               wdata_i,
  input logic [31:0]               rdata_o,
  input logic [NUM_GROUPS*32-1:0]  func_o
);
  import pinmux_pkg::*;

  logic mapped;
  assign mapped = addr_mapped(GROUP_KINDS, NUM_GROUPS, int'(addr_i));

  // R6
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:16] == 16'h0);

  // R5
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[31:16] == 16'h0) |=> $stable(func_o));

  // R8
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mapped) |=> $stable(func_o));

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == 32'h0);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(func_o));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    if (kind_of(GROUP_KINDS, g) == KIND_GPIO) begin : g_gpio
      // R7
      gpio_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        func_o[g*32 +: 32] == 32'h0);
    end else if (kind_of(GROUP_KINDS, g) == KIND_W2) begin : g_w2
      for (genvar p = 0; p < 8; p++) begin : g_pin
        // R9
        narrow_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          func_o[g*32 + 4*p + 2 +: 2] == 2'b00);
      end
    end
  end
endmodule

bind pinmux_regbank pinmux_regbank_chk #(
  .NUM_GROUPS(NUM_GROUPS), .GROUP_KINDS(GROUP_KINDS), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/pinmux_regbank_tb.sv
module pinmux_regbank_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   addr_i = '0;
  logic         wr_i = 1'b0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [127:0] func_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    bit          is_func;
    int          pin;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  pinmux_regbank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .func_o(func_o)
  );

  // monitor: compare queued expectations against the outputs
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_func ? {28'h0, func_o[4*it.pin +: 4]} : rdata_o;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        if (it.is_func)
          $display("FAIL %s pin %0d act %h exp %h", it.req, it.pin, act, it.exp);
        else
          $display("FAIL %s addr %h act %h exp %h", it.req, addr_i, act, it.exp);
      end
    end
  end

  task automatic settle();
    @(negedge clk_i); #1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic exp_read(input logic [7:0] a, input logic [31:0] e, input string req);
    addr_i = a;
    sb_q.push_back('{1'b0, 0, e, req});
    settle();
  endtask

  task automatic exp_func(input int pin, input logic [3:0] e, input string req);
    sb_q.push_back('{1'b1, pin, {28'h0, e}, req});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act hung exp done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    settle();

    // R1 reset state
    for (int i = 0; i < 32; i++) exp_func(i, 4'h0, "R1");
    exp_read(8'h00, 32'h0, "R1");
    exp_read(8'h08, 32'h0, "R1");
    exp_read(8'h10, 32'h0, "R1");

    // R3 R6 R9 2-bit group fields
    do_write(8'h00, 32'hFFFF_E41B);
    exp_read(8'h00, 32'h0000_E41B, "R3_R6");
    exp_func(0, 4'd3, "R3"); exp_func(1, 4'd2, "R3");
    exp_func(2, 4'd1, "R3"); exp_func(3, 4'd0, "R3");
    exp_func(4, 4'd0, "R9"); exp_func(5, 4'd1, "R9");
    exp_func(6, 4'd2, "R9"); exp_func(7, 4'd3, "R9");
    settle();

    // R5 mask clears low byte only
    do_write(8'h00, 32'h00FF_0000);
    exp_read(8'h00, 32'h0000_E400, "R5");
    exp_func(0, 4'd0, "R5"); exp_func(7, 4'd3, "R5");
    settle();

    // R4 4-bit group split over two registers
    do_write(8'h04, 32'hFFFF_4321);
    do_write(8'h08, 32'hFFFF_FEDC);
    exp_read(8'h04, 32'h0000_4321, "R4");
    exp_read(8'h08, 32'h0000_FEDC, "R4");
    exp_func(8, 4'h1, "R4");  exp_func(11, 4'h4, "R4");
    exp_func(12, 4'hC, "R4"); exp_func(15, 4'hF, "R4");
    settle();

    // R5 nibble-wide partial mask
    do_write(8'h08, 32'h0F00_0500);
    exp_read(8'h08, 32'h0000_F5DC, "R5");
    exp_func(14, 4'h5, "R5"); exp_func(13, 4'hD, "R5");
    settle();

    // R2 group after the GPIO-only group starts at 0x0C
    do_write(8'h0C, 32'hFFFF_AAAA);
    do_write(8'h10, 32'hFFFF_0009);
    exp_read(8'h0C, 32'h0000_AAAA, "R2");
    exp_read(8'h10, 32'h0000_0009, "R2");
    exp_func(24, 4'hA, "R2"); exp_func(27, 4'hA, "R2");
    exp_func(28, 4'h9, "R2"); exp_func(29, 4'h0, "R2");
    exp_func(12, 4'hC, "R2");
    // R7 GPIO-only pins stay 0
    for (int i = 16; i < 24; i++) exp_func(i, 4'h0, "R7");
    settle();

    // R8 hole and misaligned offsets
    do_write(8'h14, 32'hFFFF_FFFF);
    do_write(8'h02, 32'hFFFF_FFFF);
    do_write(8'h0A, 32'hFFFF_FFFF);
    exp_read(8'h14, 32'h0, "R8");
    exp_read(8'h02, 32'h0, "R8");
    exp_func(0, 4'd0, "R8"); exp_func(4, 4'd0, "R8");
    exp_func(8, 4'h1, "R8"); exp_func(14, 4'h5, "R8");
    exp_func(20, 4'h0, "R8"); exp_func(29, 4'h0, "R8");
    settle();

    // R10 write lands on the strobed edge, not before
    @(posedge clk_i); #1;
    addr_i = 8'h00; wdata_i = 32'h0003_0002; wr_i = 1'b1;
    exp_func(0, 4'd0, "R10");
    @(negedge clk_i);
    @(posedge clk_i); #1;
    wr_i = 1'b0; wdata_i = '0;
    exp_func(0, 4'd2, "R10");
    exp_read(8'h00, 32'h0000_E402, "R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule